// File: doc/BRIEF.md
# Reloadable Periodic Tick Timer

This block is a small memory-mapped timer that produces a regular heartbeat for a processor. Software loads a 24-bit period value and chooses whether the count advances on every core clock or on each rising edge of a slow external tick signal. It then enables counting. The counter steps down once per selected tick. When it leaves one and lands on zero, the block raises a sticky status flag and, if allowed, a one-cycle interrupt request. On the next tick it restarts from the period value.

Four word registers sit on a plain single-cycle 32-bit bus. A read returns data in the same cycle as the access. A write takes effect at the clock edge that ends the access. The bus offsets are: 0x0 configuration and status, 0x4 period (reload), 0x8 live count, 0xC a fixed calibration word. Only `bus_addr_i[3:2]` selects the register; the other address bits are ignored. The external tick input is asynchronous to the clock. The block synchronizes it and detects its rising edges.

Top module: `tick_timer`

## Requirements
- R1: After reset, the configuration register at 0x0, the period register at 0x4 and the count at 0x8 all read 0, and `tick_irq_o` is low.
- R2: With bit 0 (run) and bit 2 (core-clock source) of 0x0 both set, the count drops by one on every clock edge while it is above zero.
- R3: A tick that finds the count at zero loads the count from bits [23:0] of the period register. A period write made in that same cycle is used only from the next wrap onward.
- R4: A tick that moves the count from 1 to 0 sets the status flag, which reads back in bit 16 of 0x0. Bit 16 cannot be written.
- R5: A read of 0x0 returns the flag as it was before the access and clears it at the end of the access. If a 1-to-0 transition happens in the cycle of that read, the flag stays set.
- R6: Any write to 0x8, whatever its data, sets the count to zero and clears the flag. This write takes priority over a tick in the same cycle.
- R7: With bit 2 of 0x0 clear, the count moves one step for each rising edge of `ext_tick_i`, after a two-flop synchronizer. A level held high counts only once, and the clock alone does not advance the count.
- R8: `tick_irq_o` is high for exactly the one cycle that follows a 1-to-0 transition, and only if bit 1 of 0x0 was set when the transition happened.
- R9: Bits [31:24] of 0x4 and 0x8 always read as zero, and written values in those bits are discarded.
- R10: When the period register holds zero, a running count stays at zero and never sets the flag or raises the interrupt request.
- R11: Offset 0xC always reads the parameter `CAL_VALUE`, and writes to it change nothing.
- R12: With bit 0 of 0x0 clear, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_tick_i | input | 1 | Asynchronous external reference tick |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (4) | Byte offset; bits [3:2] pick the register |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Read data, valid in the access cycle |
| tick_irq_o | output | 1 | One-cycle interrupt request pulse |

## Verification
The sharpest collision is a read of the configuration/status word in the very cycle in which a tick takes the count from 1 to 0. The read must return the old flag, and the flag must still be set afterwards. The bench provokes this by following its own model of the count until the model reaches one, then issuing the read at that exact cycle and reading the register twice more. A second collision is a write to the count register that lands on a wrap or transition tick. Random traffic creates it often, because the period values are kept small. It is judged by comparing every read and every cycle of `tick_irq_o` against the bench's model.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

   typedef enum logic [1:0] {
      SEL_CONFIG  = 2'd0,
      SEL_PERIOD  = 2'd1,
      SEL_COUNT   = 2'd2,
      SEL_CALIB   = 2'd3
   } reg_sel_e;

   localparam int unsigned CFG_RUN_BIT = 0;
   localparam int unsigned CFG_IE_BIT  = 1;
   localparam int unsigned CFG_SRC_BIT = 2;

   typedef struct packed {
      logic src_core;
      logic irq_en;
      logic run;
   } tick_cfg_t;

endpackage

// File: rtl/tick_sync_edge.sv
module tick_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tick_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/tick_regbus.sv
module tick_regbus
   import tick_timer_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned CNT_W     = 24,
   parameter int unsigned FLAG_BIT  = 16,
   parameter logic [DATA_W-1:0] CAL_VALUE = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sel_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              flag_i,
   output tick_cfg_t         cfg_o,
   output logic [CNT_W-1:0]  period_o,
   output logic              wr_count_o,
   output logic              rd_config_o,
   output logic [DATA_W-1:0] rdata_o
);

   if (ADDR_W < 4) begin : g_bad_addr
      $error("tick_regbus: ADDR_W must be at least 4");
   end
   if (FLAG_BIT >= DATA_W || FLAG_BIT <= CFG_SRC_BIT) begin : g_bad_flag
      $error("tick_regbus: FLAG_BIT out of range");
   end

   reg_sel_e which;
   logic     wr_cfg, wr_period;
   logic     unused_addr;
   logic     unused_wdata;

   assign which        = reg_sel_e'(addr_i[3:2]);
   assign unused_addr  = ^addr_i;
   assign unused_wdata = ^wdata_i;

   assign wr_cfg      = sel_i &  wr_i & (which == SEL_CONFIG);
   assign wr_period   = sel_i &  wr_i & (which == SEL_PERIOD);
   assign wr_count_o  = sel_i &  wr_i & (which == SEL_COUNT);
   assign rd_config_o = sel_i & ~wr_i & (which == SEL_CONFIG);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_o    <= '0;
         period_o <= '0;
      end else begin
         if (wr_cfg) begin
            cfg_o.run      <= wdata_i[CFG_RUN_BIT];
            cfg_o.irq_en   <= wdata_i[CFG_IE_BIT];
            cfg_o.src_core <= wdata_i[CFG_SRC_BIT];
         end
         if (wr_period) begin
            period_o <= wdata_i[CNT_W-1:0];
         end
      end
   end

   logic [DATA_W-1:0] cfg_word;

   always_comb begin
      cfg_word              = '0;
      cfg_word[CFG_RUN_BIT] = cfg_o.run;
      cfg_word[CFG_IE_BIT]  = cfg_o.irq_en;
      cfg_word[CFG_SRC_BIT] = cfg_o.src_core;
      cfg_word[FLAG_BIT]    = flag_i;
   end

   always_comb begin
      unique case (which)
         SEL_CONFIG: rdata_o = cfg_word;
         SEL_PERIOD: rdata_o = DATA_W'(period_o);
         SEL_COUNT:  rdata_o = DATA_W'(cnt_i);
         default:    rdata_o = CAL_VALUE;
      endcase
   end

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             clr_i,
   input  logic             rd_clr_i,
   input  logic             irq_en_i,
   input  logic [CNT_W-1:0] period_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             flag_o,
   output logic             irq_o
);

   if (CNT_W < 2) begin : g_bad_width
      $error("tick_counter: CNT_W must be at least 2");
   end

   logic hit_zero;
   logic at_zero;

   assign at_zero  = (cnt_o == '0);
   assign hit_zero = tick_i & ~clr_i & (cnt_o == CNT_W'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_o <= '0;
      end else if (clr_i) begin
         cnt_o <= '0;
      end else if (tick_i) begin
         cnt_o <= at_zero ? period_i : cnt_o - CNT_W'(1);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_o <= 1'b0;
      end else if (clr_i) begin
         flag_o <= 1'b0;
      end else if (hit_zero) begin
         flag_o <= 1'b1;
      end else if (rd_clr_i) begin
         flag_o <= 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         irq_o <= 1'b0;
      end else begin
         irq_o <= hit_zero & irq_en_i;
      end
   end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned CNT_W       = 24,
   parameter int unsigned FLAG_BIT    = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] CAL_VALUE = 32'h4000_2710
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ext_tick_i,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              tick_irq_o
);

   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("tick_timer: CNT_W must not exceed DATA_W");
   end

   tick_cfg_t        cfg_q;
   logic [CNT_W-1:0] period_q;
   logic [CNT_W-1:0] cnt_val;
   logic             flag_q;
   logic             wr_count;
   logic             rd_config;
   logic             ext_rise;
   logic             step_en;
   logic             cfg_run, cfg_ie, cfg_src;

   assign cfg_run = cfg_q.run;
   assign cfg_ie  = cfg_q.irq_en;
   assign cfg_src = cfg_q.src_core;

   tick_sync_edge #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (ext_tick_i),
      .rise_o  (ext_rise)
   );

   assign step_en = cfg_run & (cfg_src | ext_rise);

   tick_regbus #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .CNT_W     (CNT_W),
      .FLAG_BIT  (FLAG_BIT),
      .CAL_VALUE (CAL_VALUE)
   ) u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sel_i       (bus_sel_i),
      .wr_i        (bus_wr_i),
      .addr_i      (bus_addr_i),
      .wdata_i     (bus_wdata_i),
      .cnt_i       (cnt_val),
      .flag_i      (flag_q),
      .cfg_o       (cfg_q),
      .period_o    (period_q),
      .wr_count_o  (wr_count),
      .rd_config_o (rd_config),
      .rdata_o     (bus_rdata_o)
   );

   tick_counter #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (step_en),
      .clr_i    (wr_count),
      .rd_clr_i (rd_config),
      .irq_en_i (cfg_ie),
      .period_i (period_q),
      .cnt_o    (cnt_val),
      .flag_o   (flag_q),
      .irq_o    (tick_irq_o)
   );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
   parameter int unsigned CNT_W = 24
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             irq_i,
   input logic [CNT_W-1:0] cnt_i,
   input logic [CNT_W-1:0] period_i,
   input logic             run_i,
   input logic             ie_i,
   input logic             src_i,
   input logic             flag_i,
   input logic             wr_count_i
);

   AST_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && src_i && !wr_count_i && cnt_i > CNT_W'(1)) |=> (cnt_i == $past(cnt_i) - CNT_W'(1))); // R2

   AST_WRAP_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && src_i && !wr_count_i && cnt_i == '0) |=> (cnt_i == $past(period_i))); // R3

   AST_FLAG_ON_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && src_i && !wr_count_i && cnt_i == CNT_W'(1)) |=> flag_i); // R4

   AST_COUNT_WRITE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_count_i |=> (cnt_i == '0 && !flag_i)); // R6

   AST_IRQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i |=> !irq_i); // R8

   AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i |-> ($past(ie_i) && flag_i && cnt_i == '0)); // R8

   AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i && !wr_count_i) |=> $stable(cnt_i)); // R12

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .irq_i      (tick_irq_o),
   .cnt_i      (cnt_val),
   .period_i   (period_q),
   .run_i      (cfg_run),
   .ie_i       (cfg_ie),
   .src_i      (cfg_src),
   .flag_i     (flag_q),
   .wr_count_i (wr_count)
);

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;

   localparam int CLK_P = 10;
   localparam logic [31:0] CAL = 32'h4000_2710;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_tick = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int errors = 0;
   int checks = 0;

   logic [23:0] m_cnt = '0, m_per = '0;
   logic        m_run = 0, m_ie = 0, m_src = 0, m_flag = 0;
   logic        s1 = 0, s2 = 0, sd = 0;
   logic        ext_lvl = 0;

   always #(CLK_P/2) clk = ~clk;

   tick_timer #(.CAL_VALUE(CAL)) dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .ext_tick_i  (ext_tick),
      .bus_sel_i   (bus_sel),
      .bus_wr_i    (bus_wr),
      .bus_addr_i  (bus_addr),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .tick_irq_o  (irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] read_model(input logic [3:0] a);
      case (a[3:2])
         2'd0:    return {15'b0, m_flag, 13'b0, m_src, m_ie, m_run};
         2'd1:    return {8'b0, m_per};
         2'd2:    return {8'b0, m_cnt};
         default: return CAL;
      endcase
   endfunction

   task automatic step(input logic sel, input logic wr, input logic [3:0] addr,
                       input logic [31:0] wd, input string tag);
      logic rise, tick, wcnt, rcfg, ev, exp_irq;
      ext_tick  = ext_lvl;
      bus_sel   = sel;
      bus_wr    = wr;
      bus_addr  = addr;
      bus_wdata = wd;
      #1;
      if (sel && !wr) check(tag, bus_rdata, read_model(addr));
      rise = s2 & ~sd;
      tick = m_run & (m_src | rise);
      wcnt = sel & wr & (addr[3:2] == 2'd2);
      rcfg = sel & ~wr & (addr[3:2] == 2'd0);
      ev   = 1'b0;
      if (wcnt) begin
         m_cnt = '0; m_flag = 1'b0;
      end else begin
         if (tick) begin
            if (m_cnt == 0) m_cnt = m_per;
            else begin
               if (m_cnt == 1) ev = 1'b1;
               m_cnt = m_cnt - 1;
            end
         end
         if (ev) m_flag = 1'b1;
         else if (rcfg) m_flag = 1'b0;
      end
      exp_irq = ev & m_ie;
      if (sel && wr && addr[3:2] == 2'd0) begin
         m_run = wd[0]; m_ie = wd[1]; m_src = wd[2];
      end
      if (sel && wr && addr[3:2] == 2'd1) m_per = wd[23:0];
      sd = s2; s2 = s1; s1 = ext_lvl;
      @(posedge clk);
      @(negedge clk);
      check("R8 irq", {31'b0, irq}, {31'b0, exp_irq});
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b1, 1'b0, 4'h8, '0, tag);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(CLK_P * 190000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      check("R1 irq", {31'b0, irq}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset values
      step(1, 0, 4'h0, '0, "R1 cfg");
      step(1, 0, 4'h4, '0, "R1 period");
      step(1, 0, 4'h8, '0, "R1 count");
      // R9: upper bits discarded
      step(1, 1, 4'h4, 32'hFF00_0005, "R9");
      step(1, 0, 4'h4, '0, "R9 period");
      step(1, 1, 4'h8, 32'hFFFF_FFFF, "R6");
      step(1, 0, 4'h8, '0, "R9 count");
      // R2/R3/R4: core clock, irq enabled
      step(1, 1, 4'h0, 32'h0001_0007, "R4");
      idle(14, "R2 R3");
      step(1, 0, 4'h0, '0, "R4 flag");
      // R5: read of config coincides with 1-to-0 transition
      while (m_cnt != 1) step(1, 0, 4'h8, '0, "R2");
      step(1, 0, 4'h0, '0, "R5 same-cycle");
      step(1, 0, 4'h0, '0, "R5 kept");
      step(1, 0, 4'h0, '0, "R5 cleared");
      // R6: write to count clears while running
      while (m_cnt != 3) idle(1, "R3");
      step(1, 1, 4'h8, 32'h1234_5678, "R6");
      step(1, 0, 4'h8, '0, "R6 count");
      while (m_cnt != 1) idle(1, "R3");
      idle(1, "R4");
      step(1, 1, 4'h8, '0, "R6");
      step(1, 0, 4'h0, '0, "R6 flag");
      // R8: irq disabled
      step(1, 1, 4'h0, 32'h5, "R8");
      idle(12, "R8");
      // R10: zero period
      step(1, 1, 4'h4, 32'h0, "R10");
      step(1, 1, 4'h8, 32'h0, "R10");
      step(1, 1, 4'h0, 32'h7, "R10");
      idle(20, "R10 count");
      step(1, 0, 4'h0, '0, "R10 flag");
      // R12: stopped
      step(1, 1, 4'h4, 32'd10, "R12");
      idle(4, "R12");
      step(1, 1, 4'h0, 32'h6, "R12");
      idle(10, "R12 hold");
      // R7: external ticks
      step(1, 1, 4'h0, 32'h3, "R7");
      for (int k = 0; k < 6; k++) begin
         ext_lvl = 1'b1; idle(2 + k, "R7 high");
         ext_lvl = 1'b0; idle(3, "R7 low");
      end
      ext_lvl = 1'b1; idle(15, "R7 held");
      ext_lvl = 1'b0; idle(5, "R7");
      // R11: calibration
      step(1, 0, 4'hC, '0, "R11");
      step(1, 1, 4'hC, 32'hDEAD_BEEF, "R11");
      step(1, 0, 4'hC, '0, "R11 after write");
      // random traffic
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] wd;
         logic [3:0]  ad;
         logic        sel, wr;
         sel = ($urandom_range(0, 2) != 0);
         wr  = ($urandom_range(0, 4) == 0);
         ad  = 4'($urandom);
         wd  = $urandom;
         if (ad[3:2] == 2'd1) wd = wd & 32'hFF00_001F;
         if (ad[3:2] == 2'd0 && $urandom_range(0, 3) != 0) wd[0] = 1'b1;
         if ($urandom_range(0, 3) == 0) ext_lvl = ~ext_lvl;
         step(sel, wr, ad, wd, "R2 random");
      end
      finish_run();
   end

endmodule